// File: doc/BRIEF.md
# Three-Wire UART Packet Framer

This block turns a packet request into the byte stream that a UART transmitter sends over a three-wire host link. A request names a packet type and a payload length. The block builds the four-byte packet header from that request. The header holds the acknowledge number, the sequence number and reliable flag (reliable types only), the type, the 12-bit length and a checksum. The block then takes that many payload bytes from a streaming input. It wraps the whole packet in delimiter bytes and byte-stuffs every header and payload byte, so that no delimiter value appears inside the frame.

A request can instead ask for one of four fixed link-establishment messages: sync request, sync response, config request and config response. The block supplies the payload for these messages itself, including the window field of the config request. The sequence and acknowledge numbers come from an external tracker and are captured when the request is accepted. When the frame of a reliable packet has left the block, a one-cycle pulse tells the tracker to advance its sequence number and arm its retransmit timer.

All three byte interfaces use valid/ready handshaking: the request, the payload input and the byte output.

Top module: `tw_uart_pkt_tx`

## Requirements
- R1: Every frame begins and ends with the byte 0xC0, and no 0xC0 appears between those two delimiters.
- R2: Inside a frame, a header or payload byte of 0xC0 goes out as 0xDB then 0xDC, and a byte of 0xDB goes out as 0xDB then 0xDD.
- R3: Header byte 0 bits 5:3 carry the acknowledge input value captured when the request is accepted. Bit 6 is always 0.
- R4: Packet types 1, 2, 4 and 5 set header byte 0 bit 7 to 1 and bits 2:0 to the captured sequence input. All other types leave bit 7 and bits 2:0 at zero.
- R5: Header byte 1 holds the length bits 3:0 in its bits 7:4 and the type in its bits 3:0. Header byte 2 holds the length bits 11:4.
- R6: Header byte 3 equals the bitwise inverse of the low 8 bits of (byte 0 + byte 1 + byte 2).
- R7: A link request sends type 15 with an internally generated payload. The link select values give these payloads: 0 gives 01 7E (sync request), 1 gives 02 7D (sync response), 2 gives 03 FC followed by a byte holding the window value in bits 2:0 with the upper bits zero (config request), and 3 gives 04 7B (config response). The payload input is not consumed for a link request.
- R8: A request of length zero sends the opening delimiter, the four header bytes and the closing delimiter, with no payload handshake.
- R9: While the output is valid and not ready, the output valid stays high and the output byte stays unchanged. While the first byte (0xDB) of an escape pair is offered, the payload input is not ready.
- R10: A one-cycle completion pulse appears in the cycle after the closing-delimiter handshake of a frame whose reliable flag is set, and never for other frames.
- R11: After reset the output is not valid and the request input is ready. The request input stays not ready from acceptance until the closing delimiter has been handed over.

Each frame is sent in this order: opening delimiter, header bytes 0 to 3, payload, closing delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_type | input | 4 | Packet type (ignored for link requests) |
| req_len | input | LEN_W | Payload length in bytes (ignored for link requests) |
| req_link | input | 1 | Send a fixed link-establishment message instead |
| req_link_sel | input | 2 | Which link message: 0 sync req, 1 sync rsp, 2 config req, 3 config rsp |
| cfg_window | input | 3 | Window value placed in the config request |
| seq_num | input | 3 | Sequence number from the tracker |
| ack_num | input | 3 | Acknowledge number from the tracker |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| tx_valid | output | 1 | Output byte offered to the UART |
| tx_ready | input | 1 | UART takes the byte |
| tx_data | output | 8 | Framed, stuffed output byte |
| rel_done | output | 1 | Reliable frame completed (one-cycle pulse) |

## Verification
On every cycle, the embedded assertions check four things. No bare delimiter may appear inside a frame. Every 0xDB handed over is followed by a valid 0xDC or 0xDD. The output byte is held while it is stalled. The completion pulse may only follow a closing-delimiter handshake. The scoreboard is what shows that the header fields are correct: the acknowledge and sequence placement, the reliable flag chosen by type, the length split and the checksum. The scoreboard also covers the four link payloads, the zero-length frame and the pulse count across reliable and unreliable traffic. These results come from comparing every emitted byte with a frame computed independently while the output ready is throttled at random.

// File: rtl/tw_pkg.sv
package tw_pkg;
   localparam logic [7:0] FRAME_DELIM = 8'hC0;
   localparam logic [7:0] ESC_LEAD    = 8'hDB;
   localparam logic [7:0] ESC_OF_DLM  = 8'hDC;
   localparam logic [7:0] ESC_OF_ESC  = 8'hDD;
   localparam logic [3:0] LINK_TYPE   = 4'hF;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OPEN,
      ST_HDR,
      ST_BODY,
      ST_CLOSE
   } frm_state_e;
endpackage

// File: rtl/tw_hdr_build.sv
module tw_hdr_build #(
   parameter int          LEN_W    = 12,
   parameter logic [15:0] REL_MASK = 16'h0036
) (
   input  logic [3:0]       ptype,
   input  logic [LEN_W-1:0] plen,
   input  logic [2:0]       seq,
   input  logic [2:0]       ack,
   output logic [3:0][7:0]  hdr,
   output logic             reliable
);
   localparam int FULL_W = 12;

   logic [15:0]       rel_vec;
   logic [FULL_W-1:0] len12;
   logic [7:0]        b0, b1, b2, sum;

   for (genvar t = 0; t < 16; t++) begin : g_rel
      assign rel_vec[t] = REL_MASK[t];
   end

   if (LEN_W == FULL_W) begin : g_full
      assign len12 = plen;
   end else begin : g_pad
      assign len12 = {{(FULL_W-LEN_W){1'b0}}, plen};
   end

   always_comb begin
      reliable = rel_vec[ptype];
      b0       = {reliable, 1'b0, ack, (reliable ? seq : 3'd0)};
      b1       = {len12[3:0], ptype};
      b2       = len12[11:4];
      sum      = b0 + b1 + b2;
      hdr[0]   = b0;
      hdr[1]   = b1;
      hdr[2]   = b2;
      hdr[3]   = ~sum;
   end
endmodule

// File: rtl/tw_link_msg.sv
module tw_link_msg (
   input  logic [1:0] sel,
   input  logic [1:0] idx,
   input  logic [2:0] window,
   output logic [7:0] msg_byte,
   output logic [1:0] msg_len
);
   always_comb begin
      msg_len  = (sel == 2'd2) ? 2'd3 : 2'd2;
      msg_byte = 8'h00;
      case (sel)
         2'd0: msg_byte = (idx == 2'd0) ? 8'h01 : 8'h7E;
         2'd1: msg_byte = (idx == 2'd0) ? 8'h02 : 8'h7D;
         2'd2: begin
            case (idx)
               2'd0:    msg_byte = 8'h03;
               2'd1:    msg_byte = 8'hFC;
               default: msg_byte = {5'd0, window};
            endcase
         end
         default: msg_byte = (idx == 2'd0) ? 8'h04 : 8'h7B;
      endcase
   end
endmodule

// File: rtl/tw_slip_stuff.sv
module tw_slip_stuff
   import tw_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   output logic       in_ready,
   input  logic [7:0] in_data,
   input  logic       in_raw,
   output logic       out_valid,
   input  logic       out_ready,
   output logic [7:0] out_data
);
   logic       esc_pend;
   logic       needs_esc;
   logic [7:0] second;

   always_comb begin
      needs_esc = !in_raw && (in_data == FRAME_DELIM || in_data == ESC_LEAD);
      second    = (in_data == FRAME_DELIM) ? ESC_OF_DLM : ESC_OF_ESC;
      out_valid = in_valid;
      out_data  = esc_pend ? second : (needs_esc ? ESC_LEAD : in_data);
      in_ready  = out_ready && (!needs_esc || esc_pend);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         esc_pend <= 1'b0;
      end else if (esc_pend) begin
         if (out_ready) esc_pend <= 1'b0;
      end else if (in_valid && out_ready && needs_esc) begin
         esc_pend <= 1'b1;
      end
   end

   // R9: a stalled byte is held
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data));

   // R2: an escape lead is always followed by its code byte
   p_esc_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_data == ESC_LEAD |=>
         out_valid && (out_data == ESC_OF_DLM || out_data == ESC_OF_ESC));
endmodule

// File: rtl/tw_uart_pkt_tx.sv
module tw_uart_pkt_tx
   import tw_pkg::*;
#(
   parameter int          LEN_W    = 12,
   parameter logic [15:0] REL_MASK = 16'h0036
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [3:0]       req_type,
   input  logic [LEN_W-1:0] req_len,
   input  logic             req_link,
   input  logic [1:0]       req_link_sel,
   input  logic [2:0]       cfg_window,
   input  logic [2:0]       seq_num,
   input  logic [2:0]       ack_num,
   input  logic             pl_valid,
   output logic             pl_ready,
   input  logic [7:0]       pl_data,
   output logic             tx_valid,
   input  logic             tx_ready,
   output logic [7:0]       tx_data,
   output logic             rel_done
);
   localparam int HDR_BYTES = 4;
   localparam int HIDX_W    = $clog2(HDR_BYTES);

   if (LEN_W < 2 || LEN_W > 12) begin : g_bad_len
      $error("LEN_W must lie between 2 and 12");
   end

   frm_state_e       state;
   logic [HIDX_W-1:0] hidx;
   logic [LEN_W-1:0] pcnt;
   logic [3:0]       c_type;
   logic [LEN_W-1:0] c_len;
   logic [2:0]       c_seq, c_ack, c_win;
   logic             c_link;
   logic [1:0]       c_sel;

   logic [3:0][7:0]  hdr;
   logic             hdr_rel;
   logic [7:0]       lmsg_byte;
   logic [1:0]       lmsg_len;
   logic [1:0]       lmsg_len_new;
   logic [7:0]       lmsg_unused;

   logic             s_valid, s_ready, s_raw;
   logic [7:0]       s_data;
   logic             s_hs;

   tw_hdr_build #(.LEN_W(LEN_W), .REL_MASK(REL_MASK)) u_hdr (
      .ptype(c_type), .plen(c_len), .seq(c_seq), .ack(c_ack),
      .hdr(hdr), .reliable(hdr_rel));

   tw_link_msg u_lmsg (
      .sel(c_sel), .idx(pcnt[1:0]), .window(c_win),
      .msg_byte(lmsg_byte), .msg_len(lmsg_len));

   tw_link_msg u_lmsg_len (
      .sel(req_link_sel), .idx(2'd0), .window(3'd0),
      .msg_byte(lmsg_unused), .msg_len(lmsg_len_new));

   tw_slip_stuff u_stuff (
      .clk(clk), .rst_n(rst_n),
      .in_valid(s_valid), .in_ready(s_ready), .in_data(s_data), .in_raw(s_raw),
      .out_valid(tx_valid), .out_ready(tx_ready), .out_data(tx_data));

   always_comb begin
      s_valid  = 1'b0;
      s_data   = FRAME_DELIM;
      s_raw    = 1'b0;
      pl_ready = 1'b0;
      case (state)
         ST_OPEN, ST_CLOSE: begin
            s_valid = 1'b1;
            s_raw   = 1'b1;
         end
         ST_HDR: begin
            s_valid = 1'b1;
            s_data  = hdr[hidx];
         end
         ST_BODY: begin
            if (c_link) begin
               s_valid = 1'b1;
               s_data  = lmsg_byte;
            end else begin
               s_valid  = pl_valid;
               s_data   = pl_data;
               pl_ready = s_ready;
            end
         end
         default: ;
      endcase
      s_hs      = s_valid && s_ready;
      req_ready = (state == ST_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         hidx     <= '0;
         pcnt     <= '0;
         c_type   <= '0;
         c_len    <= '0;
         c_seq    <= '0;
         c_ack    <= '0;
         c_win    <= '0;
         c_link   <= 1'b0;
         c_sel    <= '0;
         rel_done <= 1'b0;
      end else begin
         rel_done <= 1'b0;
         case (state)
            ST_IDLE: if (req_valid) begin
               c_seq  <= seq_num;
               c_ack  <= ack_num;
               c_link <= req_link;
               c_sel  <= req_link_sel;
               c_win  <= cfg_window;
               if (req_link) begin
                  c_type <= LINK_TYPE;
                  c_len  <= LEN_W'(lmsg_len_new);
               end else begin
                  c_type <= req_type;
                  c_len  <= req_len;
               end
               state <= ST_OPEN;
            end
            ST_OPEN: if (s_hs) begin
               hidx  <= '0;
               state <= ST_HDR;
            end
            ST_HDR: if (s_hs) begin
               hidx <= hidx + 1'b1;
               if (hidx == HIDX_W'(HDR_BYTES-1)) begin
                  pcnt  <= '0;
                  state <= (c_len == '0) ? ST_CLOSE : ST_BODY;
               end
            end
            ST_BODY: if (s_hs) begin
               pcnt <= pcnt + 1'b1;
               if (pcnt == c_len - 1'b1) state <= ST_CLOSE;
            end
            ST_CLOSE: if (s_hs) begin
               rel_done <= hdr_rel;
               state    <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R1: no bare delimiter between the opening and closing delimiter
   p_no_bare_delim_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && (state == ST_HDR || state == ST_BODY) |->
         tx_data != FRAME_DELIM);

   // R10: completion pulse only right after a closing delimiter handover
   p_done_after_close_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rel_done |-> $past(tx_valid && tx_ready && tx_data == FRAME_DELIM));

   // R11: no new request while a frame is in flight
   p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready && tx_data != FRAME_DELIM |-> !req_ready);
endmodule

// File: tb/sim_tw_uart_pkt_tx.sv
module sim_tw_uart_pkt_tx;
   localparam int LEN_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_ready;
   logic [3:0]       req_type = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic             req_link = 1'b0;
   logic [1:0]       req_link_sel = '0;
   logic [2:0]       cfg_window = '0;
   logic [2:0]       seq_num = '0;
   logic [2:0]       ack_num = '0;
   logic             pl_valid = 1'b0;
   logic             pl_ready;
   logic [7:0]       pl_data = '0;
   logic             tx_valid;
   logic             tx_ready = 1'b0;
   logic [7:0]       tx_data;
   logic             rel_done;

   int checks = 0;
   int failures = 0;
   int rel_seen = 0;
   int rel_exp = 0;
   bit rdy_all = 1'b1;
   bit run_ready = 1'b0;

   logic [7:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   tw_uart_pkt_tx #(.LEN_W(LEN_W)) u0 (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // output ready pattern
   initial forever begin
      @(negedge clk);
      tx_ready = run_ready && (rdy_all || ($urandom % 4 != 0));
   end

   // monitor: compare handed-over bytes with the scoreboard
   initial begin
      bit         prev_stall = 1'b0;
      logic [7:0] prev_data = '0;
      bit         prev_rel = 1'b0;
      forever begin
         @(negedge clk); #5;
         if (rst_n) begin
            if (prev_stall)
               chk(tx_valid && tx_data == prev_data, "R9", "stalled byte held",
                   int'(tx_data), int'(prev_data));
            if (tx_valid && tx_data == 8'hDB)
               chk(!pl_ready, "R9", "payload stalled during escape lead",
                   int'(pl_ready), 0);
            if (rel_done) begin
               rel_seen++;
               chk(!prev_rel, "R10", "pulse width one cycle", 1, 0);
            end
            prev_rel = rel_done;
            if (tx_valid && tx_ready) begin
               if (exp_q.size() == 0) begin
                  chk(1'b0, "R1", "unexpected output byte", int'(tx_data), 0);
               end else begin
                  logic [7:0] e;
                  string      t;
                  e = exp_q.pop_front();
                  t = tag_q.pop_front();
                  chk(tx_data == e, t, "output byte", int'(tx_data), int'(e));
               end
            end
            prev_stall = tx_valid && !tx_ready;
            prev_data  = tx_data;
         end
      end
   end

   function automatic void push_stuffed(input logic [7:0] b, input string t);
      if (b == 8'hC0) begin
         exp_q.push_back(8'hDB); tag_q.push_back("R2");
         exp_q.push_back(8'hDC); tag_q.push_back("R2");
      end else if (b == 8'hDB) begin
         exp_q.push_back(8'hDB); tag_q.push_back("R2");
         exp_q.push_back(8'hDD); tag_q.push_back("R2");
      end else begin
         exp_q.push_back(b); tag_q.push_back(t);
      end
   endfunction

   // build expected frame; returns whether reliable
   function automatic bit push_frame(input logic [3:0] ty, input logic [11:0] ln,
                                     input logic [2:0] sq, input logic [2:0] ak,
                                     input logic [7:0] pay[$]);
      logic [7:0] h0, h1, h2, h3;
      bit rel;
      rel = (ty == 4'd1 || ty == 4'd2 || ty == 4'd4 || ty == 4'd5); // R4
      h0 = {rel, 1'b0, ak, rel ? sq : 3'd0};                         // R3, R4
      h1 = {ln[3:0], ty};                                            // R5
      h2 = ln[11:4];
      h3 = ~(h0 + h1 + h2);                                          // R6
      exp_q.push_back(8'hC0); tag_q.push_back("R1");
      push_stuffed(h0, "R3/R4");
      push_stuffed(h1, "R5");
      push_stuffed(h2, "R5");
      push_stuffed(h3, "R6");
      foreach (pay[i]) push_stuffed(pay[i], (ty == 4'hF) ? "R7" : "R2");
      exp_q.push_back(8'hC0); tag_q.push_back((ln == 0) ? "R8" : "R1");
      return rel;
   endfunction

   task automatic do_req(input bit lk);
      bit got;
      @(negedge clk);
      req_valid = 1'b1;
      req_link  = lk;
      do begin
         #5 got = req_ready;
         @(negedge clk);
      end while (!got);
      req_valid = 1'b0;
      #5 chk(!req_ready, "R11", "busy after accept", int'(req_ready), 0);
   endtask

   task automatic drive_pay(input logic [7:0] pay[$]);
      foreach (pay[i]) begin
         bit got;
         @(negedge clk);
         pl_valid = 1'b1;
         pl_data  = pay[i];
         do begin
            #5 got = pl_ready;
            @(negedge clk);
         end while (!got);
         pl_valid = 1'b0;
      end
   endtask

   task automatic wait_done();
      int n = 0;
      while (exp_q.size() != 0 && n < 20000) begin
         @(negedge clk);
         n++;
      end
      repeat (4) @(negedge clk);
      chk(exp_q.size() == 0, "R1", "frame fully emitted", exp_q.size(), 0);
      chk(rel_seen == rel_exp, "R10", "completion pulse count", rel_seen, rel_exp);
   endtask

   task automatic send_pkt(input logic [3:0] ty, input logic [2:0] sq,
                           input logic [2:0] ak, input logic [7:0] pay[$]);
      logic [11:0] ln;
      ln = 12'(pay.size());
      if (push_frame(ty, ln, sq, ak, pay)) rel_exp++;
      req_type = ty; req_len = ln; seq_num = sq; ack_num = ak;
      fork
         do_req(1'b0);
         drive_pay(pay);
      join
      wait_done();
   endtask

   task automatic send_link(input logic [1:0] sel, input logic [2:0] win,
                            input logic [2:0] sq, input logic [2:0] ak);
      logic [7:0] pay[$];
      case (sel)   // R7 payload table
         2'd0: pay = '{8'h01, 8'h7E};
         2'd1: pay = '{8'h02, 8'h7D};
         2'd2: pay = '{8'h03, 8'hFC, {5'd0, win}};
         default: pay = '{8'h04, 8'h7B};
      endcase
      void'(push_frame(4'hF, 12'(pay.size()), sq, ak, pay));
      req_link_sel = sel; cfg_window = win; seq_num = sq; ack_num = ak;
      req_type = 4'h2; req_len = 12'd9;  // ignored for link requests
      do_req(1'b1);
      chk(!pl_ready, "R7", "payload input not used", int'(pl_ready), 0);
      wait_done();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [7:0] p[$];
      repeat (3) @(negedge clk);
      #5;
      chk(!tx_valid, "R11", "reset output idle", int'(tx_valid), 0);
      chk(req_ready, "R11", "reset request ready", int'(req_ready), 1);
      @(negedge clk);
      rst_n = 1'b1;
      run_ready = 1'b1;

      // reliable data with bytes needing escape
      p = '{8'h11, 8'hC0, 8'hDB, 8'h22, 8'hC0};
      send_pkt(4'd2, 3'd5, 3'd3, p);
      // R8: zero-length acknowledge packet, sequence ignored
      p = {};
      send_pkt(4'd0, 3'd6, 3'd7, p);

      rdy_all = 1'b0;
      // unreliable type 3
      p = '{8'hDB, 8'h00, 8'hFF};
      send_pkt(4'd3, 3'd4, 3'd1, p);
      // reliable type 1 command, type 5, type 4 long
      p = '{8'h03, 8'h0C, 8'h00};
      send_pkt(4'd1, 3'd7, 3'd2, p);
      p = '{8'hC0};
      send_pkt(4'd5, 3'd0, 3'd6, p);
      p = {};
      for (int i = 0; i < 300; i++) p.push_back(8'((i * 37) ^ 8'hC0));
      send_pkt(4'd4, 3'd1, 3'd5, p);
      // zero-length reliable
      p = {};
      send_pkt(4'd2, 3'd3, 3'd0, p);

      // R7 link messages
      send_link(2'd0, 3'd0, 3'd2, 3'd1);
      send_link(2'd1, 3'd0, 3'd5, 3'd4);
      send_link(2'd2, 3'd4, 3'd1, 3'd2);
      send_link(2'd3, 3'd7, 3'd0, 3'd3);
      rdy_all = 1'b1;
      send_link(2'd2, 3'd6, 3'd7, 3'd7);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule